// File: doc/BRIEF.md
# Enclave Translation Gate

This block sits between the page-table walker and the TLB. It judges every finished address translation before the TLB may store it. Each translation arrives as a virtual page number, the physical page number that software's page tables produced, an access kind and the core's enclave-mode flag. A pair of range registers marks out a protected physical region. A hardware-owned table describes each 4 KB page in that region: whether the entry is live, which virtual page is expected to map onto it, and which access kinds it permits.

The check guards the protected region in both directions. Code running outside enclave mode is refused any page inside the region, whatever its privilege. Enclave code reaching into the region must match the table exactly. When a translation disagrees with the table, the TLB does not take it, so the table overrides whatever mapping the operating system chose. Pages outside the region pass through unchanged.

The verdict is registered one cycle after the request. On the clock after the core leaves enclave mode, the gate raises a single-cycle TLB flush pulse. The range registers and the metadata table are written only through a privileged configuration port.

Top module: `encl_xlat_gate`

## Requirements
- R1: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. In any cycle where `rsp_valid` is low, `rsp_allow`, `rsp_fault`, `tlb_fill` and `rsp_code` are all zero. Reset drives every output to zero.
- R2: A write on `rng_we` loads the region's first physical page number and its page count at the clock edge. A count above N_PAGES is stored as N_PAGES. A physical page p is in the region when base <= p < base + count. Reset sets the count to zero, so no page is in the region. A request in the same cycle as a range write is judged against the old range.
- R3: A request with `core_encl` low whose physical page is in the region faults with code 1 (abort).
- R4: A request whose physical page is outside the region is allowed with code 0, whatever the enclave flag and the table contents.
- R5: An enclave request inside the region faults with code 2 when the entry at index (page - base) is not valid. Reset clears the valid bit of every entry.
- R6: An enclave request inside the region whose entry is valid, but whose virtual page number differs from the stored one, faults with code 3.
- R7: Access kinds are encoded 0 = read, 1 = write, 2 = execute and 3 = reserved. Permission bits are bit 0 = read, bit 1 = write and bit 2 = execute. An enclave request that passes the valid and VPN checks faults with code 4 when the bit for its kind is clear. Kind 3 always faults with code 4. When several checks fail, the priority is code 2, then code 3, then code 4.
- R8: An enclave request inside the region that passes every check is allowed with code 0.
- R9: `tlb_flush` is high for exactly one cycle, and only in the cycle after the edge at which `core_encl` was sampled low having been sampled high at the edge before. It stays low during reset.
- R10: A write on `md_we` updates entry `md_idx` (valid, VPN, permissions) at the clock edge. A lookup of that entry in the same cycle sees its previous contents, and a lookup in the next cycle sees the new ones.
- R11: Every response has exactly one of `rsp_allow` or `rsp_fault` high. `tlb_fill` equals `rsp_allow`, and a fault carries a nonzero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A translation is presented this cycle |
| req_vpn | input | VPN_W | Virtual page number of the translation |
| req_ppn | input | PPN_W | Physical page number from the walker |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| core_encl | input | 1 | Core is executing in enclave mode |
| rng_we | input | 1 | Privileged write of the range registers |
| rng_base_pn | input | PPN_W | First physical page of the protected region |
| rng_pages | input | CNT_W | Page count of the protected region |
| md_we | input | 1 | Privileged write of one metadata entry |
| md_idx | input | IDX_W | Entry index (page offset from the base) |
| md_valid | input | 1 | Valid bit to store |
| md_vpn | input | VPN_W | Expected virtual page number to store |
| md_perm | input | 3 | Permissions to store: bit 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | A verdict is present |
| rsp_allow | output | 1 | Translation accepted |
| rsp_fault | output | 1 | Translation refused |
| rsp_code | output | 3 | 0 ok, 1 abort, 2 invalid, 3 VPN mismatch, 4 permission |
| tlb_fill | output | 1 | TLB may install the translation |
| tlb_flush | output | 1 | One-cycle pulse after leaving enclave mode |

## Verification
Two pairs of activities can land on the same cycle. In the first, a translation arrives in the very cycle the core drops out of enclave mode. The bench drives that request with the flag already low and expects both an abort verdict and the flush pulse on the following clock. In the second, a metadata or range write coincides with a lookup of the same page. Here the reference model judges the lookup against the state held before the write, then confirms on the next request that the new contents take effect.

// File: rtl/encl_pkg.sv
package encl_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FC_OK      = 3'd0,
    FC_ABORT   = 3'd1,
    FC_INVALID = 3'd2,
    FC_VPN     = 3'd3,
    FC_PERM    = 3'd4
  } fault_code_e;

  localparam int PERM_W = 3;

endpackage

// File: rtl/encl_range_unit.sv
module encl_range_unit #(
  parameter int PPN_W   = 24,
  parameter int N_PAGES = 64,
  localparam int IDX_W  = $clog2(N_PAGES),
  localparam int CNT_W  = $clog2(N_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PPN_W-1:0] wr_base,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [PPN_W-1:0] ppn,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [PPN_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PPN_W-1:0] offset;

  // range registers; an oversized count saturates at the table depth
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (wr_en) begin
      base_q <= wr_base;
      cnt_q  <= (wr_cnt > CNT_W'(N_PAGES)) ? CNT_W'(N_PAGES) : wr_cnt;
    end
  end

  always_comb begin
    offset = ppn - base_q;
    hit    = (ppn >= base_q) && (offset < PPN_W'(cnt_q));
    idx    = offset[IDX_W-1:0];
  end

endmodule

// File: rtl/encl_meta_tbl.sv
module encl_meta_tbl
  import encl_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int N_PAGES = 64,
  localparam int IDX_W  = $clog2(N_PAGES),
  localparam int ENT_W  = VPN_W + PERM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [PERM_W-1:0] rd_perm
);

  // payload array: no reset, asynchronous read, suits distributed RAM
  logic [ENT_W-1:0]   ent_mem [N_PAGES];
  logic [N_PAGES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) ent_mem[wr_idx] <= {wr_vpn, wr_perm};
  end

  // valid bits live in flops so that reset can clear every entry at once
  for (genvar i = 0; i < N_PAGES; i++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst)                                   valid_q[i] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(i)))   valid_q[i] <= wr_valid;
    end
  end

  always_comb begin
    rd_valid          = valid_q[rd_idx];
    {rd_vpn, rd_perm} = ent_mem[rd_idx];
  end

endmodule

// File: rtl/encl_judge.sv
module encl_judge
  import encl_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic              in_region,
  input  logic              encl,
  input  logic [1:0]        kind,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [PERM_W-1:0] ent_perm,
  output fault_code_e       code
);

  logic perm_ok;

  always_comb begin
    case (acc_kind_e'(kind))
      ACC_RD:  perm_ok = ent_perm[0];
      ACC_WR:  perm_ok = ent_perm[1];
      ACC_EX:  perm_ok = ent_perm[2];
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!in_region)              code = FC_OK;
    else if (!encl)              code = FC_ABORT;
    else if (!ent_valid)         code = FC_INVALID;
    else if (ent_vpn != req_vpn) code = FC_VPN;
    else if (!perm_ok)           code = FC_PERM;
    else                         code = FC_OK;
  end

endmodule

// File: rtl/encl_xlat_gate.sv
module encl_xlat_gate
  import encl_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int N_PAGES = 64,
  localparam int IDX_W  = $clog2(N_PAGES),
  localparam int CNT_W  = $clog2(N_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PPN_W-1:0] req_ppn,
  input  logic [1:0]       req_kind,
  input  logic             core_encl,
  input  logic             rng_we,
  input  logic [PPN_W-1:0] rng_base_pn,
  input  logic [CNT_W-1:0] rng_pages,
  input  logic             md_we,
  input  logic [IDX_W-1:0] md_idx,
  input  logic             md_valid,
  input  logic [VPN_W-1:0] md_vpn,
  input  logic [2:0]       md_perm,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic             rsp_fault,
  output logic [2:0]       rsp_code,
  output logic             tlb_fill,
  output logic             tlb_flush
);

  logic              rng_hit;
  logic [IDX_W-1:0]  rng_idx;
  logic              ent_valid;
  logic [VPN_W-1:0]  ent_vpn;
  logic [PERM_W-1:0] ent_perm;
  fault_code_e       judge_code;
  logic              encl_q;

  encl_range_unit #(.PPN_W(PPN_W), .N_PAGES(N_PAGES)) u_rng (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rng_we),
    .wr_base (rng_base_pn),
    .wr_cnt  (rng_pages),
    .ppn     (req_ppn),
    .hit     (rng_hit),
    .idx     (rng_idx)
  );

  encl_meta_tbl #(.VPN_W(VPN_W), .N_PAGES(N_PAGES)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (md_we),
    .wr_idx   (md_idx),
    .wr_valid (md_valid),
    .wr_vpn   (md_vpn),
    .wr_perm  (md_perm),
    .rd_idx   (rng_idx),
    .rd_valid (ent_valid),
    .rd_vpn   (ent_vpn),
    .rd_perm  (ent_perm)
  );

  encl_judge #(.VPN_W(VPN_W)) u_judge (
    .in_region (rng_hit),
    .encl      (core_encl),
    .kind      (req_kind),
    .req_vpn   (req_vpn),
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_perm  (ent_perm),
    .code      (judge_code)
  );

  // previous enclave flag: tracked even during reset so an exit right
  // after reset release is still seen
  always_ff @(posedge clk) encl_q <= core_encl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= 3'd0;
      tlb_fill  <= 1'b0;
      tlb_flush <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && (judge_code == FC_OK);
      rsp_fault <= req_valid && (judge_code != FC_OK);
      rsp_code  <= req_valid ? judge_code : FC_OK;
      tlb_fill  <= req_valid && (judge_code == FC_OK);
      tlb_flush <= encl_q && !core_encl;
    end
  end

endmodule

// File: rtl/encl_xlat_gate_sva.sv
module encl_xlat_gate_sva (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       core_encl,
  input logic       rsp_valid,
  input logic       rsp_allow,
  input logic       rsp_fault,
  input logic [2:0] rsp_code,
  input logic       tlb_fill,
  input logic       tlb_flush
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);                                          // R1
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);                                        // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_allow && !rsp_fault && !tlb_fill && rsp_code == 3'd0)); // R1
  AST_ABORT_NON_ENCL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 3'd1) |-> !$past(core_encl));            // R3
  AST_META_FAULT_ENCL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code >= 3'd2) |-> $past(core_encl));             // R5
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_allow, rsp_fault}) == 1));          // R11
  AST_FILL_IS_ALLOW: assert property (@(posedge clk) disable iff (rst)
    tlb_fill == rsp_allow);                                            // R11
  AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_code != 3'd0));                                 // R11
  AST_FLUSH_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(core_encl) |=> tlb_flush);                                   // R9
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |=> !tlb_flush);                                         // R9

endmodule

bind encl_xlat_gate encl_xlat_gate_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .core_encl (core_encl),
  .rsp_valid (rsp_valid),
  .rsp_allow (rsp_allow),
  .rsp_fault (rsp_fault),
  .rsp_code  (rsp_code),
  .tlb_fill  (tlb_fill),
  .tlb_flush (tlb_flush)
);

// File: tb/encl_xlat_gate_test.sv
module encl_xlat_gate_test;
  localparam int VPN_W = 20;
  localparam int PPN_W = 24;
  localparam int NP    = 64;
  localparam int IDX_W = 6;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [PPN_W-1:0] req_ppn = '0;
  logic [1:0]       req_kind = '0;
  logic             core_encl = 1'b0;
  logic             rng_we = 1'b0;
  logic [PPN_W-1:0] rng_base_pn = '0;
  logic [CNT_W-1:0] rng_pages = '0;
  logic             md_we = 1'b0;
  logic [IDX_W-1:0] md_idx = '0;
  logic             md_valid = 1'b0;
  logic [VPN_W-1:0] md_vpn = '0;
  logic [2:0]       md_perm = '0;
  logic             rsp_valid, rsp_allow, rsp_fault, tlb_fill, tlb_flush;
  logic [2:0]       rsp_code;

  encl_xlat_gate uut (.*);

  // behavioural reference state
  bit     m_valid [NP];
  int     m_vpn   [NP];
  int     m_perm  [NP];
  longint m_base = 0;
  int     m_cnt  = 0;
  bit     prev_encl = 0;
  int     n_run = 0, n_fail = 0;
  bit     finished = 0;

  task automatic tick(input string tag);
    logic e_v, e_a, e_f, e_fill, e_fl;
    logic [2:0] e_c;
    longint pn;
    int ix;
    bit pok;
    e_v = req_valid && !rst;
    e_c = 3'd0;
    if (e_v) begin
      pn = longint'(req_ppn);
      if (pn >= m_base && (pn - m_base) < m_cnt) begin
        ix = int'(pn - m_base);
        case (req_kind)
          2'd0: pok = m_perm[ix][0];
          2'd1: pok = m_perm[ix][1];
          2'd2: pok = m_perm[ix][2];
          default: pok = 1'b0;
        endcase
        if (!core_encl)                 e_c = 3'd1;
        else if (!m_valid[ix])          e_c = 3'd2;
        else if (m_vpn[ix] != req_vpn)  e_c = 3'd3;
        else if (!pok)                  e_c = 3'd4;
      end
    end
    e_a = e_v && (e_c == 3'd0);
    e_f = e_v && (e_c != 3'd0);
    e_fill = e_a;
    e_fl = prev_encl && !core_encl && !rst;
    // state updates that take effect at the coming edge
    if (rst) begin
      for (int i = 0; i < NP; i++) m_valid[i] = 0;
      m_base = 0;
      m_cnt  = 0;
    end else begin
      if (rng_we) begin
        m_base = longint'(rng_base_pn);
        m_cnt  = (int'(rng_pages) > NP) ? NP : int'(rng_pages);
      end
      if (md_we) begin
        m_valid[md_idx] = md_valid;
        m_vpn[md_idx]   = int'(md_vpn);
        m_perm[md_idx]  = int'(md_perm);
      end
    end
    prev_encl = core_encl;
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (rsp_valid !== e_v || rsp_allow !== e_a || rsp_fault !== e_f ||
        rsp_code !== e_c || tlb_fill !== e_fill || tlb_flush !== e_fl) begin
      n_fail++;
      $display("FAIL %s: got v%0b a%0b f%0b c%0d fill%0b flush%0b, exp v%0b a%0b f%0b c%0d fill%0b flush%0b",
               tag, rsp_valid, rsp_allow, rsp_fault, rsp_code, tlb_fill, tlb_flush,
               e_v, e_a, e_f, e_c, e_fill, e_fl);
    end
  endtask

  task automatic idle();
    req_valid = 0; rng_we = 0; md_we = 0;
  endtask

  task automatic req(input bit encl, input int vpn, input int ppn, input int kind);
    rng_we = 0; md_we = 0;
    core_encl = encl;
    req_valid = 1;
    req_vpn  = VPN_W'(vpn);
    req_ppn  = PPN_W'(ppn);
    req_kind = 2'(kind);
  endtask

  task automatic meta(input int idx, input bit v, input int vpn, input int perm);
    md_we = 1; md_idx = IDX_W'(idx); md_valid = v;
    md_vpn = VPN_W'(vpn); md_perm = 3'(perm);
  endtask

  task automatic range(input int base, input int pages);
    rng_we = 1; rng_base_pn = PPN_W'(base); rng_pages = CNT_W'(pages);
  endtask

  localparam int B = 'h080000;

  initial begin
    rst = 1;
    repeat (3) tick("R1");
    rst = 0;
    idle(); tick("R1");                               // reset state
    req(0, 'h111, B + 3, 0); tick("R4");               // count 0 after reset (R2)
    idle(); range(B, 100); tick("R2");                 // clamped to 64
    req(0, 'h1, B + 63, 0); tick("R3");                // last page, non-enclave abort
    req(0, 'h1, B + 64, 0); tick("R2");                // just past the clamped end
    req(1, 'h1, B + 7, 0); tick("R5");                 // entries invalid after reset
    req(1, 'h10, B, 0); meta(0, 1, 'h10, 3'b011); tick("R10"); // old contents seen
    req(1, 'h10, B, 0); tick("R8");                    // new contents seen
    idle(); meta(5, 1, 'h20, 3'b100); tick("R1");
    req(1, 'h11, B, 0); tick("R6");
    req(1, 'h10, B, 1); tick("R8");
    req(1, 'h10, B, 2); tick("R7");
    req(1, 'h10, B, 3); tick("R7");                    // reserved kind
    req(1, 'h20, B + 5, 2); tick("R8");
    req(1, 'h20, B + 5, 0); tick("R7");
    req(1, 'h21, B + 5, 0); tick("R6");                // VPN beats permission
    req(1, 'h20, B + 6, 2); tick("R5");
    req(1, 'h999, 'h000123, 1); tick("R4");            // enclave, outside region
    req(0, 'h10, B, 0); tick("R9");                    // exit with a request in flight
    req(0, 'h10, B, 0); tick("R3");                    // no second flush
    idle(); tick("R1");
    core_encl = 1; tick("R9");
    core_encl = 1; tick("R9");
    core_encl = 0; tick("R9");                         // exit without a request
    idle(); tick("R9");
    core_encl = 1; meta(0, 0, 'h10, 3'b011); tick("R10");
    req(1, 'h10, B, 0); tick("R5");                    // invalidated entry
    req(1, 'h20, B + 5, 2); range(B + 'h10, 8); tick("R2"); // old range applies
    req(1, 'h20, B + 'h15, 2); tick("R2");             // new base, offset 5
    req(1, 'h20, B + 5, 2); tick("R4");                // now outside
    req(1, 'h0, B + 'h18, 0); tick("R2");              // offset 8 equals count
    req(0, 'h0, B + 'h17, 0); tick("R3");
    idle(); core_encl = 1; rst = 1; tick("R1");
    core_encl = 0; tick("R9");                         // no flush during reset
    rst = 0; idle(); range(B, 8); tick("R2");
    req(1, 'h20, B + 5, 2); tick("R5");                // reset cleared valid bits
    idle(); tick("R1");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule